// File: doc/BRIEF.md
# BPSK DAC Sample Generator

This block turns a fixed binary sequence into a two-phase keyed carrier. The output is a stream of unsigned offset-binary codes for an external digital-to-analog converter. The sequence is stored in a constant vector. A sine table that covers one full carrier period is built at elaboration time. A prescaler sets the output sample rate, and a cycle counter marks out each bit period. Every bit period holds exactly TABLE_DEPTH output samples, so the phase stride given at reset is the number of carrier periods per bit.

At the default settings the block runs from a 120 MHz clock, emits a sample every 10 cycles (12 MHz), and sends 1200 bits per second. The carrier frequency is therefore 1200 Hz times the stride: a stride of 15 gives 18 kHz and a stride of 40 gives 48 kHz. A one-bit output shows the data bit that belongs to the current sample, so the raw stream can be watched next to the modulated one.

Top module: `bpsk_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, every counter, the pattern position and the table position return to zero. Both outputs are then 0 until the first sample after release.
- R2: After reset is released, the outputs change only on the SAMPLE_DIV-th clock edge and every SAMPLE_DIV-th edge after it. Between those edges they hold their value.
- R3: Table entry i (0 <= i < TABLE_DEPTH) is MID plus sin(2*pi*i/TABLE_DEPTH)*MID truncated toward zero, where MID = 2^(DAC_W-1)-1. Every output code lies in 0 .. 2*MID. When the data bit is 1, the output equals the table entry.
- R4: When the data bit is 0, the output is 2*MID minus the table entry, which is a 180 degree phase shift.
- R5: Output sample j (counted from 0 after reset) uses table entry (j*step) mod TABLE_DEPTH. The phase carries on across bit boundaries and is never cleared at a new bit.
- R6: Each data bit lasts TABLE_DEPTH samples, which is SAMPLE_DIV*TABLE_DEPTH cycles. Sample j carries PATTERN[(j / TABLE_DEPTH) mod PATTERN_LEN], where bit 0 is the LSB. After the last pattern bit, the sequence starts again at bit 0.
- R7: `data_bit` equals the data bit used for the sample on `dac_sample`. Both are registered and change on the same edge, so a new bit first appears together with the first sample of its period.
- R8: `phase_step` is captured only while `rst` is high and is reduced modulo TABLE_DEPTH. Changing it while reset is low has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures the stride |
| phase_step | input | STEP_W (= ceil(log2(TABLE_DEPTH))) | Table stride per sample (carrier periods per bit) |
| dac_sample | output | DAC_W | Offset-binary modulated sample |
| data_bit | output | 1 | Data bit of the current sample |

## Verification
A wrong table position is visible at the very next sample. It shows up as a code that departs from the truncated-sine reference, and the error stays because the phase is never realigned. A fault in the bit counter or the pattern position first appears at the next bit boundary, as a data bit or an inverted waveform arriving one or more samples early or late. A faulty prescaler breaks the hold-between-samples behaviour within SAMPLE_DIV cycles. A stride that leaks in after reset changes the following sample.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;
   localparam real PI_C = 3.141592653589793;

   // Mid-scale code of an unsigned DAC word (also the sine amplitude)
   function automatic int mid_code(input int w);
      return (1 << (w - 1)) - 1;
   endfunction

   // Offset-binary sine point: truncate toward zero, then lift by mid-scale
   function automatic int sine_code(input int idx, input int depth, input int mid);
      real ang;
      real v;
      ang = 2.0 * PI_C * real'(idx) / real'(depth);
      v   = $sin(ang) * real'(mid);
      return $rtoi(v) + mid;
   endfunction
endpackage

// File: rtl/bpsk_modcnt.sv
module bpsk_modcnt #(
   parameter int MOD = 10,
   parameter int CW  = (MOD > 1) ? $clog2(MOD) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] LAST = CW'(MOD - 1);

   if (MOD < 2) begin : g_bad_mod
      $error("bpsk_modcnt: MOD must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (en)
         count <= (count == LAST) ? '0 : count + CW'(1);
   end
endmodule

// File: rtl/bpsk_phase_acc.sv
module bpsk_phase_acc #(
   parameter int DEPTH = 10000,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] step_in,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] step_q
);
   localparam logic [AW:0] DEPTH_X = (AW + 1)'(DEPTH);

   logic [AW:0]   step_x;
   logic [AW:0]   sum;
   logic [AW-1:0] step_r;
   logic [AW-1:0] nxt;

   always_comb begin
      step_x = {1'b0, step_in};
      step_r = (step_x >= DEPTH_X) ? AW'(step_x - DEPTH_X) : step_in;
      sum    = {1'b0, addr} + {1'b0, step_q};
      nxt    = (sum >= DEPTH_X) ? AW'(sum - DEPTH_X) : AW'(sum);
   end

   // Stride is latched only during reset; position wraps modulo DEPTH
   always_ff @(posedge clk) begin
      if (rst) begin
         addr   <= '0;
         step_q <= step_r;
      end else if (adv) begin
         addr   <= nxt;
      end
   end
endmodule

// File: rtl/bpsk_sine_rom.sv
module bpsk_sine_rom #(
   parameter int DEPTH   = 10000,
   parameter int DAC_W   = 14,
   parameter bit QUARTER = 1'b1,
   parameter int AW      = $clog2(DEPTH)
) (
   input  logic [AW-1:0]    addr,
   output logic [DAC_W-1:0] sample
);
   localparam int MID = bpsk_pkg::mid_code(DAC_W);
   localparam logic [DAC_W-1:0] FULL = DAC_W'(2 * MID);

   if (QUARTER) begin : g_quarter
      localparam int Q  = DEPTH / 4;
      localparam int QW = $clog2(Q + 1);
      localparam logic [AW-1:0] A_Q  = AW'(Q);
      localparam logic [AW-1:0] A_H  = AW'(2 * Q);
      localparam logic [AW-1:0] A_3Q = AW'(3 * Q);
      localparam logic [AW-1:0] A_F  = AW'(4 * Q);

      logic [DAC_W-1:0] qtab [0:Q];
      logic [AW-1:0]    off;
      logic             lower;
      logic [DAC_W-1:0] mag;

      for (genvar i = 0; i <= Q; i++) begin : g_pt
         assign qtab[i] = DAC_W'(bpsk_pkg::sine_code(i, DEPTH, MID));
      end

      // Fold the period onto the first quadrant
      always_comb begin
         if (addr <= A_Q) begin
            off = addr;        lower = 1'b0;
         end else if (addr < A_H) begin
            off = A_H - addr;  lower = 1'b0;
         end else if (addr <= A_3Q) begin
            off = addr - A_H;  lower = 1'b1;
         end else begin
            off = A_F - addr;  lower = 1'b1;
         end
         mag    = qtab[QW'(off)];
         sample = lower ? FULL - mag : mag;
      end
   end else begin : g_full
      logic [DAC_W-1:0] tab [0:DEPTH-1];

      for (genvar i = 0; i < DEPTH; i++) begin : g_pt
         assign tab[i] = DAC_W'(bpsk_pkg::sine_code(i, DEPTH, MID));
      end

      assign sample = tab[addr];
   end
endmodule

// File: rtl/bpsk_modulator.sv
module bpsk_modulator #(
   parameter int DAC_W        = 14,
   parameter int TABLE_DEPTH  = 10000,
   parameter int SAMPLE_DIV   = 10,
   parameter int PATTERN_LEN  = 1200,
   parameter logic [PATTERN_LEN-1:0] PATTERN =
      PATTERN_LEN'({(PATTERN_LEN + 7) / 8 {8'b10110100}}),
   parameter bit QUARTER_TABLE = 1'b1,
   parameter int STEP_W       = $clog2(TABLE_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STEP_W-1:0] phase_step,
   output logic [DAC_W-1:0]  dac_sample,
   output logic              data_bit
);
   localparam int BIT_PERIOD = SAMPLE_DIV * TABLE_DEPTH;
   localparam int PRE_W      = $clog2(SAMPLE_DIV);
   localparam int BIT_CW     = $clog2(BIT_PERIOD);
   localparam int PAT_W      = $clog2(PATTERN_LEN);
   localparam int MID        = bpsk_pkg::mid_code(DAC_W);
   localparam logic [DAC_W-1:0]  FULL     = DAC_W'(2 * MID);
   localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(SAMPLE_DIV - 1);
   localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(BIT_PERIOD - 1);

   // Elaboration-time parameter checks
   if (SAMPLE_DIV < 2)             begin : g_chk_div   $error("SAMPLE_DIV must be >= 2");      end
   if (TABLE_DEPTH < 4)            begin : g_chk_depth $error("TABLE_DEPTH must be >= 4");     end
   if (PATTERN_LEN < 2)            begin : g_chk_len   $error("PATTERN_LEN must be >= 2");     end
   if (DAC_W < 2 || DAC_W > 30)    begin : g_chk_w     $error("DAC_W out of range");           end
   if (STEP_W != $clog2(TABLE_DEPTH)) begin : g_chk_sw $error("STEP_W must be clog2(depth)");  end
   if (QUARTER_TABLE && (TABLE_DEPTH % 4 != 0)) begin : g_chk_q
      $error("quarter table needs TABLE_DEPTH divisible by 4");
   end

   logic [PRE_W-1:0]  pre_cnt;
   logic [BIT_CW-1:0] bit_cnt;
   logic [PAT_W-1:0]  pat_addr;
   logic [STEP_W-1:0] sin_addr;
   logic [STEP_W-1:0] step_q;
   logic [DAC_W-1:0]  raw;
   logic              tick;
   logic              bit_last;
   logic              cur_bit;

   bpsk_modcnt #(.MOD(SAMPLE_DIV)) u_pre (
      .clk(clk), .rst(rst), .en(1'b1), .count(pre_cnt)
   );

   bpsk_modcnt #(.MOD(BIT_PERIOD)) u_bitcnt (
      .clk(clk), .rst(rst), .en(1'b1), .count(bit_cnt)
   );

   assign tick     = (pre_cnt == PRE_LAST);
   assign bit_last = (bit_cnt == BIT_LAST);

   bpsk_modcnt #(.MOD(PATTERN_LEN)) u_patadr (
      .clk(clk), .rst(rst), .en(bit_last), .count(pat_addr)
   );

   bpsk_phase_acc #(.DEPTH(TABLE_DEPTH), .AW(STEP_W)) u_phase (
      .clk(clk), .rst(rst), .step_in(phase_step), .adv(tick),
      .addr(sin_addr), .step_q(step_q)
   );

   bpsk_sine_rom #(
      .DEPTH(TABLE_DEPTH), .DAC_W(DAC_W), .QUARTER(QUARTER_TABLE), .AW(STEP_W)
   ) u_rom (
      .addr(sin_addr), .sample(raw)
   );

   assign cur_bit = PATTERN[pat_addr];

   // Output stage: bit and sample register together on the sample tick
   always_ff @(posedge clk) begin
      if (rst) begin
         dac_sample <= '0;
         data_bit   <= 1'b0;
      end else if (tick) begin
         data_bit   <= cur_bit;
         dac_sample <= cur_bit ? raw : FULL - raw;
      end
   end
endmodule

// File: rtl/bpsk_modulator_chk.sv
module bpsk_modulator_chk #(
   parameter int P      = 10,
   parameter int N      = 10000,
   parameter int DAC_W  = 14,
   parameter int STEP_W = 14,
   parameter int BCW    = 17
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic [BCW-1:0]    bit_cnt,
   input logic [STEP_W-1:0] sin_addr,
   input logic [STEP_W-1:0] step_q,
   input logic [DAC_W-1:0]  dac_sample,
   input logic              data_bit
);
   localparam logic [DAC_W-1:0] FULL = DAC_W'(2 * bpsk_pkg::mid_code(DAC_W));

   assert_range_R3: assert property (@(posedge clk) disable iff (rst)
      dac_sample <= FULL);

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(tick) |-> ($stable(dac_sample) && $stable(data_bit)));

   assert_bitedge_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(data_bit) |-> (int'($past(bit_cnt)) % P == P - 1));

   assert_stepfrozen_R8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(step_q));

   assert_addr_R5: assert property (@(posedge clk) disable iff (rst)
      int'(sin_addr) < N);

   assert_lockstep_R6: assert property (@(posedge clk) disable iff (rst)
      tick |-> (int'(bit_cnt) % P == P - 1));
endmodule

bind bpsk_modulator bpsk_modulator_chk #(
   .P(SAMPLE_DIV), .N(TABLE_DEPTH), .DAC_W(DAC_W), .STEP_W(STEP_W), .BCW(BIT_CW)
) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .bit_cnt(bit_cnt), .sin_addr(sin_addr),
   .step_q(step_q), .dac_sample(dac_sample), .data_bit(data_bit)
);

// File: tb/sim_bpsk_modulator.sv
module sim_bpsk_modulator;
   localparam int W  = 14;
   localparam int N  = 40;
   localparam int P  = 3;
   localparam int L  = 8;
   localparam logic [L-1:0] PAT = 8'b10110100;
   localparam int SW   = $clog2(N);
   localparam int MID  = (1 << (W - 1)) - 1;
   localparam int FULL = 2 * MID;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [SW-1:0] phase_step = '0;
   logic [W-1:0]  dac_sample;
   logic          data_bit;

   always #2 clk = ~clk;

   bpsk_modulator #(
      .DAC_W(W), .TABLE_DEPTH(N), .SAMPLE_DIV(P), .PATTERN_LEN(L),
      .PATTERN(PAT), .QUARTER_TABLE(1'b1)
   ) u0 (
      .clk(clk), .rst(rst), .phase_step(phase_step),
      .dac_sample(dac_sample), .data_bit(data_bit)
   );

   typedef struct {
      int    dac;
      int    bit_v;
      string tag;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    pe = 0;
   bit    active = 1'b0;
   int    last_dac = 0;
   int    last_bit = 0;

   // Full-period reference computed directly, without quadrant folding
   function automatic int ref_entry(int a);
      real v;
      v = $sin(2.0 * 3.141592653589793 * real'(a) / real'(N)) * real'(MID);
      return $rtoi(v) + MID;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) pe <= rst ? 0 : pe + 1;

   // Monitor: pops an expected sample on every sample edge, else checks hold
   always @(negedge clk) begin
      item_t it;
      if (active && !rst) begin
         if (pe > 0 && pe % P == 0 && q.size() > 0) begin
            it = q.pop_front();
            chk(it.tag, "dac_sample", int'(dac_sample), it.dac);
            chk("R6 R7", "data_bit", int'(data_bit), it.bit_v);
            last_dac = it.dac;
            last_bit = it.bit_v;
         end else begin
            chk("R2", "hold dac_sample", int'(dac_sample), last_dac);
            chk("R2", "hold data_bit", int'(data_bit), last_bit);
         end
      end
   end

   // Driver: reset with a stride, queue the expected samples, release
   task automatic run_case(int step, int later_step, int nsamp, string tag);
      int step_eff;
      @(negedge clk);
      active = 1'b0;
      rst = 1'b1;
      phase_step = SW'(step);
      repeat (3) @(negedge clk);
      chk("R1", "reset dac_sample", int'(dac_sample), 0);
      chk("R1", "reset data_bit", int'(data_bit), 0);
      step_eff = step % N;
      for (int j = 0; j < nsamp; j++) begin
         item_t it;
         int b;
         int s;
         b = int'(PAT[(j / N) % L]);
         s = ref_entry((j * step_eff) % N);
         it.bit_v = b;
         it.dac   = (b != 0) ? s : FULL - s;
         it.tag   = (b != 0) ? {tag, " R3"} : {tag, " R4"};
         q.push_back(it);
      end
      last_dac = 0;
      last_bit = 0;
      rst = 1'b0;
      active = 1'b1;
      if (later_step >= 0) begin
         @(negedge clk);
         phase_step = SW'(later_step);
      end
      wait (q.size() == 0);
      @(negedge clk);
      active = 1'b0;
   endtask

   initial begin
      run_case(1, -1, 120, "R5");        // one carrier period per bit
      run_case(3, -1, 400, "R5 R6");     // ten bits: pattern wraps
      run_case(10, -1, 80, "R3");        // lands on peak, mid and trough
      run_case(39, -1, 100, "R5");       // stride N-1: wraps every sample
      run_case(41, -1, 60, "R8");        // stride above N is reduced mod N
      run_case(2, 7, 120, "R8");         // stride change after reset ignored
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule